// File: doc/BRIEF.md
# Oversampling Baud Generator with Receive-Idle Timeout

This block makes the timing strobes for a slow asynchronous infrared link. A 48 MHz reference clock goes first through a fixed divide-by-26 prescaler and then through a reloadable down-counter. The counter's terminal count is a single-cycle sample strobe at sixteen times the bit rate. Every sixteenth sample strobe is also marked as a bit strobe. The bit rate is (48 MHz / 26) / ((count + 1) × 16). After reset the count is 11, which gives 9600 bit/s.

A separate idle watchdog counts bit strobes while no receive activity arrives. When the selected limit is reached it raises one timeout pulse, and it stays quiet until activity restarts it. The watchdog runs only while the slow transfer mode is selected. The serializer and deserializer are outside this block and use its strobes.

Software changes the count and the timeout selector through a small write port with two addresses. A new count takes effect only when the running period ends, so the strobe spacing never changes part-way through a period.

Top module: `slow_ir_baud_gen`

## Requirements
- R1: After reset all three strobe outputs are low, the count is 11 (sample strobes 312 clocks apart) and the timeout selector is 2.
- R2: `sample_stb` is a one-cycle pulse repeating every (count + 1) × 26 clock cycles.
- R3: A write with `wr_addr` = 0 loads `wr_data[5:0]` as the new count, which is used only from the reload at the end of the running period; no period is cut short.
- R4: `bit_stb` pulses in the same cycle as every sixteenth `sample_stb`, and never at any other time.
- R5: A write with `wr_addr` = 1 loads `wr_data[9:8]` as the timeout selector. Values 0, 1 and 2 give limits of 8, 16 and 32 bit strobes, and `timeout_pulse` rises in the same cycle as the bit strobe that reaches the limit after the last receive activity.
- R6: Selector value 3 disables the timeout; no `timeout_pulse` occurs.
- R7: While `slow_mode` is low, no `timeout_pulse` occurs and the idle count is held cleared.
- R8: Each idle period yields at most one single-cycle `timeout_pulse`; a `rx_activity` pulse clears the idle count and allows a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 48 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the count register, 1 the configuration register |
| wr_data | input | 16 | Write data; count in bits 5:0, timeout selector in bits 9:8 |
| slow_mode | input | 1 | High while the slow transfer mode is selected; enables the timeout |
| rx_activity | input | 1 | One-cycle pulse for each receive event; restarts the idle count |
| sample_stb | output | 1 | 16x oversampling strobe |
| bit_stb | output | 1 | Bit-rate strobe, on every sixteenth sample strobe |
| timeout_pulse | output | 1 | One-cycle receive-idle timeout event |

## Verification
The hardest case to reach is a count change that lands in the middle of a long period. The change must not take effect until the down-counter wraps, so a write has to arrive several prescaler ticks before the terminal count. The bench writes new counts at arbitrary clock offsets while the default 312-cycle period is running. It compares every strobe against a behavioural model in every cycle. The timeout limits are exercised with the count set to 0, so the 32-bit-time limit can be reached in a short run. The bench also sends receive pulses more often than the shortest limit, to show that the restart holds back every timeout.

// File: rtl/slow_ir_pkg.sv
package slow_ir_pkg;
   typedef enum logic {
      REG_RATE = 1'b0,
      REG_CFG  = 1'b1
   } reg_sel_e;

   localparam int RATE_LSB    = 0;
   localparam int TMO_SEL_LSB = 8;
   localparam int TMO_SEL_W   = 2;
   localparam logic [TMO_SEL_W-1:0] TMO_OFF = 2'b11;
endpackage

// File: rtl/ir_prescale.sv
module ir_prescale #(
   parameter int DIV = 26
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("ir_prescale: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_bypass
         assign tick = 1'b1;
      end else begin : g_count
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] cnt_q;

         assign tick = (cnt_q == LAST);

         always_ff @(posedge clk) begin
            if (!rst_n)    cnt_q <= '0;
            else if (tick) cnt_q <= '0;
            else           cnt_q <= cnt_q + 1'b1;
         end

         a_r2_prescale_bound : assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q <= LAST);
      end
   endgenerate
endmodule

// File: rtl/ir_strobe_div.sv
module ir_strobe_div #(
   parameter int CNT_W         = 6,
   parameter int OVS           = 16,
   parameter int DEFAULT_COUNT = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pre_tick,
   input  logic [CNT_W-1:0] reload_val,
   output logic             sample_stb,
   output logic             bit_stb,
   output logic             bit_tick
);
   localparam int SUB_W = (OVS > 1) ? $clog2(OVS) : 1;
   localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(OVS - 1);

   generate
      if (DEFAULT_COUNT >= (1 << CNT_W)) begin : g_bad_default
         $error("ir_strobe_div: DEFAULT_COUNT does not fit CNT_W");
      end
      if (OVS < 2) begin : g_bad_ovs
         $error("ir_strobe_div: OVS must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] down_q;
   logic [SUB_W-1:0] sub_q;
   logic             samp_tick;

   assign samp_tick = pre_tick && (down_q == '0);
   assign bit_tick  = samp_tick && (sub_q == SUB_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         down_q     <= CNT_W'(DEFAULT_COUNT);
         sub_q      <= '0;
         sample_stb <= 1'b0;
         bit_stb    <= 1'b0;
      end else begin
         sample_stb <= samp_tick;
         bit_stb    <= bit_tick;
         if (pre_tick)
            down_q <= (down_q == '0) ? reload_val : down_q - 1'b1;
         if (samp_tick)
            sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
      end
   end

   // R3: the counter only steps down by one, except when it wraps from zero
   a_r3_no_midperiod_jump : assert property (@(posedge clk) disable iff (!rst_n)
      ((down_q != $past(down_q)) && ($past(down_q) != '0)) |-> (down_q == $past(down_q) - 1'b1));
endmodule

// File: rtl/ir_idle_timeout.sv
module ir_idle_timeout #(
   parameter int TMO_BASE = 8,
   parameter int SEL_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_en,
   input  logic [SEL_W-1:0] sel,
   input  logic             bit_tick,
   input  logic             rx_act,
   output logic             tmo_pulse
);
   import slow_ir_pkg::*;

   localparam int MAX_LIMIT = TMO_BASE << 2;
   localparam int IDLE_W    = $clog2(MAX_LIMIT + 1);

   generate
      if (TMO_BASE < 1) begin : g_bad_base
         $error("ir_idle_timeout: TMO_BASE must be at least 1");
      end
      if (SEL_W != TMO_SEL_W) begin : g_bad_sel
         $error("ir_idle_timeout: SEL_W must match the package width");
      end
   endgenerate

   logic              active;
   logic [IDLE_W-1:0] limit;
   logic [IDLE_W-1:0] idle_q;
   logic [IDLE_W-1:0] idle_nxt;
   logic              fired_q;

   assign active   = mode_en && (sel != TMO_OFF);
   assign limit    = IDLE_W'(TMO_BASE) << sel;
   assign idle_nxt = idle_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_q    <= '0;
         fired_q   <= 1'b0;
         tmo_pulse <= 1'b0;
      end else begin
         tmo_pulse <= 1'b0;
         if (rx_act || !active) begin
            idle_q  <= '0;
            fired_q <= 1'b0;
         end else if (bit_tick && !fired_q) begin
            idle_q <= idle_nxt;
            if (idle_nxt >= limit) begin
               tmo_pulse <= 1'b1;
               fired_q   <= 1'b1;
            end
         end
      end
   end

   a_r8_single_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      tmo_pulse |=> !tmo_pulse);
   a_r7_gated_by_mode : assert property (@(posedge clk) disable iff (!rst_n)
      !$past(mode_en) |-> !tmo_pulse);
   a_r8_restart_clears : assert property (@(posedge clk) disable iff (!rst_n)
      $past(rx_act) |-> (idle_q == '0) && !tmo_pulse);
endmodule

// File: rtl/slow_ir_baud_gen.sv
module slow_ir_baud_gen #(
   parameter int PRE_DIV         = 26,
   parameter int CNT_W           = 6,
   parameter int OVS             = 16,
   parameter int DEFAULT_COUNT   = 11,
   parameter int TMO_BASE        = 8,
   parameter int DEFAULT_TMO_SEL = 2,
   parameter int DATA_W          = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              slow_mode,
   input  logic              rx_activity,
   output logic              sample_stb,
   output logic              bit_stb,
   output logic              timeout_pulse
);
   import slow_ir_pkg::*;

   generate
      if (DATA_W < TMO_SEL_LSB + TMO_SEL_W) begin : g_bad_data_w
         $error("slow_ir_baud_gen: DATA_W too narrow for the selector field");
      end
      if (CNT_W + RATE_LSB > DATA_W) begin : g_bad_cnt_w
         $error("slow_ir_baud_gen: CNT_W does not fit DATA_W");
      end
      if (DEFAULT_TMO_SEL >= (1 << TMO_SEL_W)) begin : g_bad_tmo
         $error("slow_ir_baud_gen: DEFAULT_TMO_SEL out of range");
      end
   endgenerate

   logic [CNT_W-1:0]     rate_q;
   logic [TMO_SEL_W-1:0] tmo_sel_q;
   logic                 pre_tick;
   logic                 bit_tick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rate_q    <= CNT_W'(DEFAULT_COUNT);
         tmo_sel_q <= TMO_SEL_W'(DEFAULT_TMO_SEL);
      end else if (wr_en) begin
         if (reg_sel_e'(wr_addr) == REG_RATE)
            rate_q <= wr_data[RATE_LSB +: CNT_W];
         else
            tmo_sel_q <= wr_data[TMO_SEL_LSB +: TMO_SEL_W];
      end
   end

   ir_prescale #(.DIV(PRE_DIV)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (pre_tick)
   );

   ir_strobe_div #(
      .CNT_W         (CNT_W),
      .OVS           (OVS),
      .DEFAULT_COUNT (DEFAULT_COUNT)
   ) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .pre_tick   (pre_tick),
      .reload_val (rate_q),
      .sample_stb (sample_stb),
      .bit_stb    (bit_stb),
      .bit_tick   (bit_tick)
   );

   ir_idle_timeout #(
      .TMO_BASE (TMO_BASE),
      .SEL_W    (TMO_SEL_W)
   ) u_tmo (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_en   (slow_mode),
      .sel       (tmo_sel_q),
      .bit_tick  (bit_tick),
      .rx_act    (rx_activity),
      .tmo_pulse (timeout_pulse)
   );

   a_r2_sample_single_cycle : assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |=> !sample_stb);
   a_r4_bit_on_sample : assert property (@(posedge clk) disable iff (!rst_n)
      bit_stb |-> sample_stb);
   a_r5_timeout_on_bit : assert property (@(posedge clk) disable iff (!rst_n)
      timeout_pulse |-> bit_stb);
   a_r6_selector_off : assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tmo_sel_q) == TMO_OFF) |-> !timeout_pulse);
endmodule

// File: tb/slow_ir_baud_gen_tb.sv
module slow_ir_baud_gen_tb_top;
   localparam int CLK_PERIOD = 20;
   localparam int PRE       = 26;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_addr = 1'b0;
   logic [15:0] wr_data = '0;
   logic        slow_mode = 1'b0;
   logic        rx_activity = 1'b0;
   logic        sample_stb, bit_stb, timeout_pulse;

   int    checks = 0;
   int    errors = 0;
   int    tmo_seen = 0;
   int    cyc = 0;
   int    last_samp = -1;
   int    first_gap = -1;
   bit    done = 1'b0;
   string cur_req = "R1";

   // behavioural reference state
   int m_pre, m_down, m_pend, m_sub, m_sel, m_idle;
   bit m_fired, e_samp, e_bit, e_tmo;

   always #(CLK_PERIOD/2) clk = ~clk;

   slow_ir_baud_gen dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .slow_mode(slow_mode), .rx_activity(rx_activity),
      .sample_stb(sample_stb), .bit_stb(bit_stb), .timeout_pulse(timeout_pulse)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         m_pre = 0; m_down = 11; m_pend = 11; m_sub = 0; m_sel = 2;
         m_idle = 0; m_fired = 0; e_samp = 0; e_bit = 0; e_tmo = 0;
      end else begin
         bit t_pre, t_samp, t_bit, en;
         int lim;
         t_pre  = (m_pre == PRE - 1);
         t_samp = t_pre && (m_down == 0);
         t_bit  = t_samp && (m_sub == 15);
         m_pre  = t_pre ? 0 : m_pre + 1;
         if (t_pre) m_down = (m_down == 0) ? m_pend : m_down - 1;
         if (t_samp) m_sub = (m_sub + 1) % 16;
         en  = slow_mode && (m_sel != 3);
         lim = 8 << m_sel;
         e_tmo = 0;
         if (rx_activity || !en) begin
            m_idle = 0; m_fired = 0;
         end else if (t_bit && !m_fired) begin
            m_idle++;
            if (m_idle >= lim) begin e_tmo = 1; m_fired = 1; end
         end
         e_samp = t_samp;
         e_bit  = t_bit;
         if (wr_en) begin
            if (wr_addr == 1'b0) m_pend = wr_data[5:0];
            else                 m_sel  = wr_data[9:8];
         end
      end
   end

   task automatic check(input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%b expected=%b at cycle %0d", cur_req, what, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      cyc++;
      if (rst_n && !done) begin
         check("sample_stb", sample_stb, e_samp);
         check("bit_stb", bit_stb, e_bit);
         check("timeout_pulse", timeout_pulse, e_tmo);
         if (timeout_pulse) tmo_seen++;
         if (sample_stb) begin
            if (last_samp >= 0 && first_gap < 0) first_gap = cyc - last_samp;
            last_samp = cyc;
         end
      end
   end

   task automatic reg_write(input logic addr, input logic [15:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = addr; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse_rx();
      @(negedge clk);
      rx_activity = 1'b1;
      @(negedge clk);
      rx_activity = 1'b0;
   endtask

   task automatic count_tmo(input string req, input int exp_n);
      checks++;
      if (tmo_seen != exp_n) begin
         errors++;
         $display("FAIL %s timeout count actual=%0d expected=%0d", req, tmo_seen, exp_n);
      end
   endtask

   localparam int BIT0 = 26 * 16; // one bit time at count 0

   initial begin
      // R1: reset state
      repeat (5) @(negedge clk);
      checks += 3;
      if (sample_stb !== 1'b0 || bit_stb !== 1'b0 || timeout_pulse !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset outputs actual=%b%b%b expected=000", sample_stb, bit_stb, timeout_pulse);
      end
      rst_n = 1'b1;
      cur_req = "R2";
      repeat (2 * 312 * 16 + 50) @(negedge clk);
      checks++;
      if (first_gap != 312) begin
         errors++;
         $display("FAIL R1 default period actual=%0d expected=312", first_gap);
      end
      // R3: count changes at odd offsets mid-period
      cur_req = "R3";
      repeat (97) @(negedge clk);
      reg_write(1'b0, 16'h0003);
      repeat (1500) @(negedge clk);
      reg_write(1'b0, 16'hFFC5); // upper bits ignored, count 5
      repeat (2000) @(negedge clk);
      reg_write(1'b0, 16'h0000);
      cur_req = "R4";
      repeat (40 * BIT0) @(negedge clk);
      // R5: selector 2 -> 32 bit times
      cur_req = "R5";
      slow_mode = 1'b1;
      pulse_rx();
      tmo_seen = 0;
      repeat (40 * BIT0) @(negedge clk);
      count_tmo("R5", 1);
      // R5: selector 0 and 1
      reg_write(1'b1, 16'h0000);
      pulse_rx(); tmo_seen = 0;
      repeat (12 * BIT0) @(negedge clk);
      count_tmo("R5", 1);
      reg_write(1'b1, 16'h0100);
      pulse_rx(); tmo_seen = 0;
      repeat (20 * BIT0) @(negedge clk);
      count_tmo("R5", 1);
      // R8: frequent activity holds off the timeout; then one pulse only
      cur_req = "R8";
      reg_write(1'b1, 16'h0000);
      pulse_rx(); tmo_seen = 0;
      for (int i = 0; i < 8; i++) begin
         repeat (5 * BIT0) @(negedge clk);
         pulse_rx();
      end
      count_tmo("R8", 0);
      repeat (30 * BIT0) @(negedge clk);
      count_tmo("R8", 1);
      // R6: selector 3 disables
      cur_req = "R6";
      reg_write(1'b1, 16'h0300);
      pulse_rx(); tmo_seen = 0;
      repeat (40 * BIT0) @(negedge clk);
      count_tmo("R6", 0);
      // R7: fast mode gates the timeout
      cur_req = "R7";
      reg_write(1'b1, 16'h0000);
      slow_mode = 1'b0;
      pulse_rx(); tmo_seen = 0;
      repeat (20 * BIT0) @(negedge clk);
      count_tmo("R7", 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (199000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL %s watchdog expired actual=running expected=finished", cur_req);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule